// File: doc/BRIEF.md
# Barrel Shifter With Carry-Out

This block forms the second ALU operand of a 32-bit RISC datapath together with the shifter carry that goes with it. It has three operand variants. An immediate can pass straight through. A register value can be shifted by an amount encoded in the instruction. A register value can also be shifted by an amount read from a second register. The caller supplies the register value, the amount byte, the shift kind and the incoming carry flag. The block supplies the final operand and its carry-out.

When the operand register is the program counter, the block first applies the pipeline read-ahead offset. This offset is twice the current instruction size. The carry-out rule depends on two things: the shift kind, and whether the amount is zero, between 1 and 32, or larger than 32. The rotate-extended kind brings the incoming carry into bit 31.

Both outputs are registered, so the operand for the inputs presented before a clock edge appears after that edge. A synchronous active-high reset clears the outputs.

Top module: `barrel_shift_unit`

## Requirements
- R1: With operand variant 0 (immediate), `result` equals `operand` and `carry_out` equals `carry_in`. The program-counter adjustment is not applied.
- R2: For variants 1 and 2 with shift kinds 0 to 3, an amount byte of 0 leaves the (adjusted) operand unchanged and sets `carry_out` to `carry_in`.
- R3: Shift kind 0 (logical left) by n in 1..32 gives operand << n with carry = operand bit (32−n). For n > 32 both result and carry are 0.
- R4: Shift kind 1 (logical right) by n in 1..32 gives operand >> n with carry = operand bit (n−1). For n > 32 both result and carry are 0.
- R5: Shift kind 2 (arithmetic right) by n in 1..32 fills the vacated bits with bit 31 and sets carry = operand bit (n−1). For n > 32 every result bit and the carry equal bit 31.
- R6: Shift kind 3 (rotate right) by a nonzero n rotates by n mod 32. The carry equals bit 31 of the rotated result.
- R7: Shift kind 4 (rotate extended) ignores the amount. It gives {carry_in, operand[31:1]} with carry = operand bit 0.
- R8: For variants 1 and 2 with `src_is_pc` high, the operand is first increased by 8 when `narrow_isa` is 0 and by 4 when `narrow_isa` is 1.
- R9: Shift kinds 5 to 7 give result 0 with carry = `carry_in`. Variant 3 gives all ones with carry = `carry_in`.
- R10: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge. Reset clears `result` and `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant | input | 2 | Operand variant: 0 immediate, 1 immediate-amount shift, 2 register-amount shift, 3 invalid |
| shift_kind | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5-7 unused |
| operand | input | 32 | Immediate or source register value |
| amount | input | 8 | Shift amount byte (low byte of the amount source) |
| src_is_pc | input | 1 | Source register is the program counter |
| narrow_isa | input | 1 | 1 when 16-bit instructions are executing, 0 for 32-bit |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifter operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Each result is due exactly one rising edge after its inputs are applied, because the shift network is combinational and feeds one output register. The bench drives every stimulus on a falling edge and compares the outputs on the next falling edge, half a cycle after the capturing edge. One check reads the outputs just after a new stimulus is driven and before any edge, to confirm that nothing moves early. The bound checker relates each output to the inputs of the previous cycle with single-cycle `|=>` properties.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  typedef enum logic [1:0] {
    OV_IMM     = 2'd0,
    OV_IMM_SH  = 2'd1,
    OV_REG_SH  = 2'd2,
    OV_INVALID = 2'd3
  } op_variant_e;
endpackage

// File: rtl/bsu_pc_adjust.sv
module bsu_pc_adjust #(
  parameter int DATA_W     = 32,
  parameter int WIDE_INSN  = 4,
  parameter int NARROW_INSN = 2
) (
  input  logic [DATA_W-1:0] val_in,
  input  logic              is_pc,
  input  logic              narrow,
  output logic [DATA_W-1:0] val_out
);
  localparam logic [DATA_W-1:0] WIDE_OFS   = DATA_W'(2 * WIDE_INSN);
  localparam logic [DATA_W-1:0] NARROW_OFS = DATA_W'(2 * NARROW_INSN);

  always_comb begin
    if (!is_pc)      val_out = val_in;
    else if (narrow) val_out = val_in + NARROW_OFS;
    else             val_out = val_in + WIDE_OFS;
  end
endmodule

// File: rtl/bsu_shift_core.sv
module bsu_shift_core
  import bsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] val,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int W2   = 2 * DATA_W;
  localparam int SH_W = $clog2(DATA_W);

  logic              amt_zero;
  logic              amt_big;
  logic [W2-1:0]     lsl_wide;
  logic [DATA_W:0]   lsr_nar;
  logic [DATA_W:0]   asr_nar;
  logic [W2-1:0]     ror_wide;
  logic [SH_W-1:0]   ror_amt;

  assign amt_zero = (amt == '0);
  assign amt_big  = (int'(amt) > DATA_W);
  assign ror_amt  = amt[SH_W-1:0];

  // wide vectors hold the bit that leaves the word, which becomes the carry
  assign lsl_wide = {{DATA_W{1'b0}}, val} << amt;
  assign lsr_nar  = {val, 1'b0} >> amt;
  assign asr_nar  = $unsigned($signed({val, 1'b0}) >>> amt);
  assign ror_wide = {val, val} >> ror_amt;

  always_comb begin
    res  = val;
    cout = cin;
    case (kind)
      SK_LSL: begin
        if (amt_big) begin
          res  = '0;
          cout = 1'b0;
        end else if (!amt_zero) begin
          res  = lsl_wide[DATA_W-1:0];
          cout = lsl_wide[DATA_W];
        end
      end
      SK_LSR: begin
        if (amt_big) begin
          res  = '0;
          cout = 1'b0;
        end else if (!amt_zero) begin
          res  = lsr_nar[DATA_W:1];
          cout = lsr_nar[0];
        end
      end
      SK_ASR: begin
        if (amt_big) begin
          res  = {DATA_W{val[DATA_W-1]}};
          cout = val[DATA_W-1];
        end else if (!amt_zero) begin
          res  = asr_nar[DATA_W:1];
          cout = asr_nar[0];
        end
      end
      SK_ROR: begin
        if (!amt_zero) begin
          res  = ror_wide[DATA_W-1:0];
          cout = ror_wide[DATA_W-1];
        end
      end
      SK_RRX: begin
        res  = {cin, val[DATA_W-1:1]};
        cout = val[0];
      end
      default: begin
        res  = '0;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        variant,
  input  logic [2:0]        shift_kind,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  logic              src_is_pc,
  input  logic              narrow_isa,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic [DATA_W-1:0] src_adj;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_cout;

  bsu_pc_adjust #(.DATA_W(DATA_W)) u_pc_adj (
    .val_in (operand),
    .is_pc  (src_is_pc),
    .narrow (narrow_isa),
    .val_out(src_adj)
  );

  bsu_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .kind(shift_kind),
    .val (src_adj),
    .amt (amount),
    .cin (carry_in),
    .res (sh_res),
    .cout(sh_cout)
  );

  always_comb begin
    case (op_variant_e'(variant))
      OV_IMM: begin
        nxt_res  = operand;
        nxt_cout = carry_in;
      end
      OV_IMM_SH, OV_REG_SH: begin
        nxt_res  = sh_res;
        nxt_cout = sh_cout;
      end
      default: begin
        nxt_res  = '1;
        nxt_cout = carry_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= nxt_res;
      carry_out <= nxt_cout;
    end
  end
endmodule

// File: rtl/barrel_shift_unit_chk.sv
module barrel_shift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        variant,
  input logic [2:0]        shift_kind,
  input logic [DATA_W-1:0] operand,
  input logic [AMT_W-1:0]  amount,
  input logic              src_is_pc,
  input logic              narrow_isa,
  input logic              carry_in,
  input logic [DATA_W-1:0] result,
  input logic              carry_out
);
  logic shifting;
  assign shifting = (variant == 2'd1) || (variant == 2'd2);

  // R1
  imm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (variant == 2'd0) |=> (result == $past(operand)) && (carry_out == $past(carry_in)));

  // R2
  zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && !src_is_pc && shift_kind <= 3'd3 && amount == '0)
      |=> (result == $past(operand)) && (carry_out == $past(carry_in)));

  // R3
  lsl_big_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && shift_kind == 3'd0 && int'(amount) > DATA_W)
      |=> (result == '0) && !carry_out);

  // R7
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && !src_is_pc && shift_kind == 3'd4)
      |=> (result == {$past(carry_in), $past(operand[DATA_W-1:1])})
          && (carry_out == $past(operand[0])));

  // R8
  pc_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && src_is_pc && narrow_isa && shift_kind == 3'd0 && amount == '0)
      |=> result == $past(operand) + DATA_W'(4));

  // R9
  bad_variant_chk: assert property (@(posedge clk) disable iff (rst)
    (variant == 2'd3) |=> (result == '1) && (carry_out == $past(carry_in)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result == '0) && !carry_out);
endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .variant   (variant),
  .shift_kind(shift_kind),
  .operand   (operand),
  .amount    (amount),
  .src_is_pc (src_is_pc),
  .narrow_isa(narrow_isa),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  variant;
  logic [2:0]  shift_kind;
  logic [31:0] operand;
  logic [7:0]  amount;
  logic        src_is_pc;
  logic        narrow_isa;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  barrel_shift_unit u_barrel_shift_unit (
    .clk(clk), .rst(rst), .variant(variant), .shift_kind(shift_kind),
    .operand(operand), .amount(amount), .src_is_pc(src_is_pc),
    .narrow_isa(narrow_isa), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  // Bit-serial reference model built from the requirements.
  function automatic logic [32:0] model(logic [1:0] v, logic [2:0] k, logic [31:0] op,
                                        logic [7:0] amt, logic pc, logic nar, logic ci);
    logic [31:0] x;
    logic        c;
    int          n;
    if (v == 2'd0) return {ci, op};
    if (v == 2'd3) return {ci, 32'hFFFF_FFFF};
    x = pc ? op + (nar ? 32'd4 : 32'd8) : op;
    c = ci;
    n = int'(amt);
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin c = x[31]; x = {x[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin c = x[0]; x = {1'b0, x[31:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin c = x[0]; x = {x[31], x[31:1]}; end
      3'd3: if (n != 0) begin
              for (int i = 0; i < n % 32; i++) x = {x[0], x[31:1]};
              c = x[31];
            end
      3'd4: begin c = x[0]; x = {ci, x[31:1]}; end
      default: x = 32'd0;
    endcase
    return {c, x};
  endfunction

  function automatic string tag_for(logic [1:0] v, logic [2:0] k, logic [7:0] amt, logic pc);
    if (v == 2'd0) return "R1";
    if (v == 2'd3) return "R9";
    if (pc) return "R8";
    if (amt == 8'd0 && k <= 3'd3) return "R2";
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(string tag, logic [31:0] exp_r, logic exp_c);
    checks++;
    if (result !== exp_r || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b (var=%0d kind=%0d op=%h amt=%0d pc=%b nar=%b cin=%b)",
               tag, result, carry_out, exp_r, exp_c, variant, shift_kind, operand, amount,
               src_is_pc, narrow_isa, carry_in);
    end
  endtask

  // Called on a falling edge; result is due after the next rising edge.
  task automatic apply(logic [1:0] v, logic [2:0] k, logic [31:0] op, logic [7:0] amt,
                       logic pc, logic nar, logic ci);
    logic [32:0] e;
    variant = v; shift_kind = k; operand = op; amount = amt;
    src_is_pc = pc; narrow_isa = nar; carry_in = ci;
    e = model(v, k, op, amt, pc, nar, ci);
    @(negedge clk);
    compare(tag_for(v, k, amt, pc), e[31:0], e[32]);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL R10: watchdog expired, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [7:0]  amts [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F69; pats[3] = 32'h0123_4567;
    amts[0] = 8'd63; amts[1] = 8'd64; amts[2] = 8'd100;
    amts[3] = 8'd128; amts[4] = 8'd200; amts[5] = 8'd255;

    rst = 1'b1; variant = 2'd0; shift_kind = 3'd0; operand = 32'hFFFF_FFFF;
    amount = 8'd0; src_is_pc = 1'b0; narrow_isa = 1'b0; carry_in = 1'b1;
    @(negedge clk); @(negedge clk);
    compare("R10", 32'd0, 1'b0);
    rst = 1'b0;

    // R10: nothing moves before the capturing edge
    apply(2'd0, 3'd0, 32'h1357_9BDF, 8'd0, 1'b0, 1'b0, 1'b1);
    operand = 32'h2468_ACE0; carry_in = 1'b0;
    #1;
    compare("R10", 32'h1357_9BDF, 1'b1);
    @(negedge clk);
    compare("R10", 32'h2468_ACE0, 1'b0);

    // Main sweep: variants 1 and 2, every kind, amounts 0..40 and large bytes
    for (int p = 0; p < 4; p++)
      for (int v = 1; v <= 2; v++)
        for (int k = 0; k < 8; k++)
          for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a <= 40; a++)
              apply(2'(v), 3'(k), pats[p], 8'(a), 1'b0, 1'b0, 1'(ci));
            for (int a = 0; a < 6; a++)
              apply(2'(v), 3'(k), pats[p], amts[a], 1'b0, 1'b0, 1'(ci));
          end

    // R8: program-counter offset in both instruction sizes
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 5; k++)
        for (int nar = 0; nar < 2; nar++)
          for (int a = 0; a < 34; a += 3)
            apply(2'd2, 3'(k), pats[p], 8'(a), 1'b1, 1'(nar), 1'b1);

    // R1 and R9: immediate and invalid variant ignore shift, amount and pc
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        for (int ci = 0; ci < 2; ci++) begin
          apply(2'd0, 3'(k), pats[p], 8'd5, 1'b1, 1'b0, 1'(ci));
          apply(2'd3, 3'(k), pats[p], 8'd7, 1'b1, 1'b1, 1'(ci));
        end

    // R10: synchronous reset clears the registered outputs
    apply(2'd3, 3'd0, 32'd0, 8'd0, 1'b0, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    compare("R10", 32'd0, 1'b0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule